// File: doc/BRIEF.md
# Extended-Page Opcode Decoder with Interrupt Control State

This block sits beside the instruction decoder of an 8-bit processor core. The core hands it the second byte of an extended-page instruction. Each byte the core presents is turned, one cycle later, into three outputs: a compact action code, a register or register-pair select, and, for port reads, the flag byte to write back. Undocumented duplicate encodings are folded onto their documented counterparts. Every variant of the interrupt-return opcode therefore behaves the same way, and the spare interrupt-mode encodings select the same modes as the official ones.

The block also owns the interrupt-control state: a two-bit interrupt mode and the two interrupt-enable flip-flops (the live enable and its saved copy). Four things change this state: the decoded operations, enable and disable requests from the main decoder, and acknowledges of non-maskable and maskable interrupts. When a maskable interrupt is acknowledged in mode 1, the block supplies the fixed restart vector. In the other modes it signals that the vector must come from the data bus.

Top module: `edp_intctl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, act_valid, vec_fixed and vec_from_bus are 0, iff1 and iff2 are 0 and int_mode is 0.
- R2: Every byte 01xxx100 (44h, 4Ch … 7Ch) yields action NEG (code 1) with reg_sel 0.
- R3: Every byte 01xxx101 (45h, 4Dh … 7Dh) yields action RETN (code 2), and on the next cycle iff1 equals the iff2 value held when the byte was taken; iff2 is unchanged.
- R4: Bytes 46h, 4Eh, 66h and 6Eh set int_mode to 0; 56h and 76h set it to 1; 5Eh and 7Eh set it to 2. The action is SETIM (code 3), reg_sel carries the mode, and int_mode never holds 3.
- R5: Byte 01rrr000 yields IN_REG (code 4) with reg_sel = rrr, except 70h, which yields IN_TEST (code 6) with reg_sel 6 and no store. For both, flags_out = {S=d[7], Z=(d==0), d[5], H=0, d[3], P=even parity of d, N=0, C=carry_in}, most significant bit first. For all other actions flags_out is 0.
- R6: Byte 01rrr001 yields OUT_REG (code 5) with reg_sel = rrr, except 71h, which yields OUT_ZERO (code 7) with reg_sel 6.
- R7: Byte 01ppq010 yields SUB16 (code 8, q=0) or ADD16 (code 9, q=1), and byte 01ppq011 yields ST16 (code 10, q=0) or LD16 (code 11, q=1). In all four, reg_sel = {0,pp}, so 63h and 6Bh select pair 2 (HL).
- R8: Bytes 77h and 7Fh yield NOP (code 0). The other bytes 01rrr111 yield SPECIAL (code 12) with reg_sel = rrr.
- R9: A byte outside 40h–7Fh yields NOP with reg_sel 0. act_valid follows op_valid one cycle later.
- R10: ei_req sets iff1 and iff2, and di_req clears both. nmi_ack copies iff1 into iff2 and clears iff1. When several of these arrive in one cycle, the later entry in this order wins: RETN, ei_req, di_req, nmi_ack, irq_ack.
- R11: irq_ack while iff1=1 clears iff1 and iff2. On the next cycle, mode 1 gives vec_fixed=1 with vec_addr=38h; modes 0 and 2 give vec_from_bus=1.
- R12: irq_ack while iff1=0 is ignored. No vector output is raised, and the enables and the mode stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | op_byte holds an extended-page byte this cycle |
| op_byte | input | 8 | Second byte of the extended-page instruction |
| port_data | input | 8 | Value read from the port, for flag computation |
| carry_in | input | 1 | Current carry flag, preserved by port reads |
| ei_req | input | 1 | Enable-interrupts request |
| di_req | input | 1 | Disable-interrupts request |
| nmi_ack | input | 1 | Non-maskable interrupt acknowledged |
| irq_ack | input | 1 | Maskable interrupt acknowledge cycle |
| act_valid | output | 1 | Decoded outputs are valid |
| act_code | output | 4 | Action code |
| reg_sel | output | 3 | Register, pair or mode selected |
| flags_out | output | 8 | Flag byte for port reads, else 0 |
| int_mode | output | 2 | Current interrupt mode |
| iff1 | output | 1 | Live interrupt enable |
| iff2 | output | 1 | Saved interrupt enable |
| vec_fixed | output | 1 | Fixed restart vector is valid |
| vec_addr | output | 8 | Restart address when vec_fixed is 1 |
| vec_from_bus | output | 1 | Vector must be read from the data bus |

## Verification
Some properties are checked by assertions on every cycle. Every interrupt-return variant copies the saved enable into the live one. Every byte ending in 100 becomes NEG. Port reads clear H and N. The mode register never reaches 3. A mode-1 acknowledge always produces address 38h. The bench scenarios cover the rest. They exercise the full decode table across the duplicate encodings and the sequences that move the enable flip-flops (enable, non-maskable entry, return). They also exercise acknowledges that must be ignored when interrupts are disabled, and the parity and zero flags over several data patterns.

// File: rtl/edp_pkg.sv
package edp_pkg;
    localparam int OPW   = 8;
    localparam int SELW  = 3;
    localparam int MODEW = 2;

    typedef enum logic [3:0] {
        ACT_NOP      = 4'd0,
        ACT_NEG      = 4'd1,
        ACT_RETN     = 4'd2,
        ACT_SETIM    = 4'd3,
        ACT_IN_REG   = 4'd4,
        ACT_OUT_REG  = 4'd5,
        ACT_IN_TEST  = 4'd6,
        ACT_OUT_ZERO = 4'd7,
        ACT_SUB16    = 4'd8,
        ACT_ADD16    = 4'd9,
        ACT_ST16     = 4'd10,
        ACT_LD16     = 4'd11,
        ACT_SPECIAL  = 4'd12
    } act_e;

    typedef struct packed {
        logic             act_valid;
        act_e             act;
        logic [SELW-1:0]  sel;
        logic [7:0]       flags;
        logic [MODEW-1:0] im;
        logic             iff1;
        logic             iff2;
        logic             vec_fixed;
        logic             vec_bus;
    } st_t;
endpackage

// File: rtl/edp_decode.sv
module edp_decode
    import edp_pkg::*;
(
    input  logic [OPW-1:0]   op,
    output act_e             act,
    output logic [SELW-1:0]  sel,
    output logic             im_wr,
    output logic [MODEW-1:0] im_val
);
    logic [2:0] low3;
    logic [2:0] mid3;
    assign low3 = op[2:0];
    assign mid3 = op[5:3];

    always_comb begin
        act    = ACT_NOP;
        sel    = '0;
        im_wr  = 1'b0;
        im_val = '0;
        if (op[7:6] == 2'b01) begin
            unique case (low3)
                3'd0: begin
                    act = (mid3 == 3'd6) ? ACT_IN_TEST : ACT_IN_REG;
                    sel = mid3;
                end
                3'd1: begin
                    act = (mid3 == 3'd6) ? ACT_OUT_ZERO : ACT_OUT_REG;
                    sel = mid3;
                end
                3'd2: begin
                    act = op[3] ? ACT_ADD16 : ACT_SUB16;
                    sel = {1'b0, op[5:4]};
                end
                3'd3: begin
                    act = op[3] ? ACT_LD16 : ACT_ST16;
                    sel = {1'b0, op[5:4]};
                end
                3'd4: act = ACT_NEG;
                3'd5: act = ACT_RETN;
                3'd6: begin
                    act   = ACT_SETIM;
                    im_wr = 1'b1;
                    unique case (op[4:3])
                        2'b00, 2'b01: im_val = 2'd0;
                        2'b10:        im_val = 2'd1;
                        default:      im_val = 2'd2;
                    endcase
                    sel = {1'b0, im_val};
                end
                default: begin
                    if (op[5:4] == 2'b11) begin
                        act = ACT_NOP;
                    end else begin
                        act = ACT_SPECIAL;
                        sel = mid3;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/edp_inflags.sv
module edp_inflags
    import edp_pkg::*;
(
    input  logic [OPW-1:0] data,
    input  logic           carry,
    output logic [7:0]     flags
);
    always_comb begin
        flags    = '0;
        flags[7] = data[OPW-1];
        flags[6] = (data == '0);
        flags[5] = data[5];
        flags[4] = 1'b0;
        flags[3] = data[3];
        flags[2] = ~^data;
        flags[1] = 1'b0;
        flags[0] = carry;
    end
endmodule

// File: rtl/edp_intctl.sv
module edp_intctl
    import edp_pkg::*;
#(
    parameter logic [7:0] FIXED_VECTOR = 8'h38
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [7:0]       op_byte,
    input  logic [7:0]       port_data,
    input  logic             carry_in,
    input  logic             ei_req,
    input  logic             di_req,
    input  logic             nmi_ack,
    input  logic             irq_ack,
    output logic             act_valid,
    output logic [3:0]       act_code,
    output logic [2:0]       reg_sel,
    output logic [7:0]       flags_out,
    output logic [1:0]       int_mode,
    output logic             iff1,
    output logic             iff2,
    output logic             vec_fixed,
    output logic [7:0]       vec_addr,
    output logic             vec_from_bus
);
    localparam logic [MODEW-1:0] MODE_FIXED = 2'd1;

    st_t              st_d, st_q;
    act_e             dec_act;
    logic [SELW-1:0]  dec_sel;
    logic             dec_im_wr;
    logic [MODEW-1:0] dec_im_val;
    logic [7:0]       in_flags;

    edp_decode u_dec (
        .op     (op_byte),
        .act    (dec_act),
        .sel    (dec_sel),
        .im_wr  (dec_im_wr),
        .im_val (dec_im_val)
    );

    edp_inflags u_flg (
        .data  (port_data),
        .carry (carry_in),
        .flags (in_flags)
    );

    always_comb begin
        st_d           = st_q;
        st_d.act_valid = op_valid;
        st_d.act       = op_valid ? dec_act : ACT_NOP;
        st_d.sel       = op_valid ? dec_sel : '0;
        st_d.flags     = (op_valid && (dec_act == ACT_IN_REG || dec_act == ACT_IN_TEST))
                         ? in_flags : '0;
        st_d.vec_fixed = 1'b0;
        st_d.vec_bus   = 1'b0;

        if (op_valid && dec_act == ACT_RETN) st_d.iff1 = st_q.iff2;
        if (op_valid && dec_im_wr)           st_d.im   = dec_im_val;
        if (ei_req) begin
            st_d.iff1 = 1'b1;
            st_d.iff2 = 1'b1;
        end
        if (di_req) begin
            st_d.iff1 = 1'b0;
            st_d.iff2 = 1'b0;
        end
        if (nmi_ack) begin
            st_d.iff2 = st_q.iff1;
            st_d.iff1 = 1'b0;
        end
        if (irq_ack && st_q.iff1) begin
            st_d.iff1 = 1'b0;
            st_d.iff2 = 1'b0;
            if (st_q.im == MODE_FIXED) st_d.vec_fixed = 1'b1;
            else                       st_d.vec_bus   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.act <= ACT_NOP;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_valid    = st_q.act_valid;
    assign act_code     = st_q.act;
    assign reg_sel      = st_q.sel;
    assign flags_out    = st_q.flags;
    assign int_mode     = st_q.im;
    assign iff1         = st_q.iff1;
    assign iff2         = st_q.iff2;
    assign vec_fixed    = st_q.vec_fixed;
    assign vec_addr     = st_q.vec_fixed ? FIXED_VECTOR : 8'h00;
    assign vec_from_bus = st_q.vec_bus;
endmodule

// File: rtl/edp_intctl_chk.sv
module edp_intctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [7:0] op_byte,
    input logic       ei_req,
    input logic       di_req,
    input logic       nmi_ack,
    input logic       irq_ack,
    input logic       act_valid,
    input logic [3:0] act_code,
    input logic [7:0] flags_out,
    input logic [1:0] int_mode,
    input logic       iff1,
    input logic       iff2,
    input logic       vec_fixed,
    input logic [7:0] vec_addr
);
    logic quiet_ctl;
    assign quiet_ctl = !ei_req && !di_req && !nmi_ack && !(irq_ack && iff1);

    AST_RETN_COPIES_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_byte[7:6] == 2'b01 && op_byte[2:0] == 3'b101 && quiet_ctl)
        |=> (iff1 == $past(iff2)) && (iff2 == $past(iff2))); // R3

    AST_NEG_FAMILY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_byte[7:6] == 2'b01 && op_byte[2:0] == 3'b100)
        |=> (act_valid && act_code == 4'd1)); // R2

    AST_IN_CLEARS_HN: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && (act_code == 4'd4 || act_code == 4'd6))
        |-> (flags_out[4] == 1'b0 && flags_out[1] == 1'b0)); // R5

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        int_mode != 2'd3); // R4

    AST_MODE1_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && iff1 && int_mode == 2'd1)
        |=> (vec_fixed && vec_addr == 8'h38 && !iff1 && !iff2)); // R11

    AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !iff1 && !ei_req && !di_req && !nmi_ack && !op_valid)
        |=> (!vec_fixed && $stable(int_mode) && $stable(iff1) && $stable(iff2))); // R12
endmodule

bind edp_intctl edp_intctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_byte   (op_byte),
    .ei_req    (ei_req),
    .di_req    (di_req),
    .nmi_ack   (nmi_ack),
    .irq_ack   (irq_ack),
    .act_valid (act_valid),
    .act_code  (act_code),
    .flags_out (flags_out),
    .int_mode  (int_mode),
    .iff1      (iff1),
    .iff2      (iff2),
    .vec_fixed (vec_fixed),
    .vec_addr  (vec_addr)
);

// File: tb/edp_intctl_test.sv
module edp_intctl_test;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [7:0] op_byte = 8'h00;
    logic [7:0] port_data = 8'h00;
    logic       carry_in = 1'b0;
    logic       ei_req = 1'b0, di_req = 1'b0, nmi_ack = 1'b0, irq_ack = 1'b0;
    logic       act_valid;
    logic [3:0] act_code;
    logic [2:0] reg_sel;
    logic [7:0] flags_out;
    logic [1:0] int_mode;
    logic       iff1, iff2, vec_fixed, vec_from_bus;
    logic [7:0] vec_addr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [3:0] act;
        logic [2:0] sel;
        logic [7:0] flg;
        string      req;
    } exp_t;
    exp_t sb[$];

    edp_intctl uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
        .port_data(port_data), .carry_in(carry_in), .ei_req(ei_req),
        .di_req(di_req), .nmi_ack(nmi_ack), .irq_ack(irq_ack),
        .act_valid(act_valid), .act_code(act_code), .reg_sel(reg_sel),
        .flags_out(flags_out), .int_mode(int_mode), .iff1(iff1), .iff2(iff2),
        .vec_fixed(vec_fixed), .vec_addr(vec_addr), .vec_from_bus(vec_from_bus)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] in_flags(input logic [7:0] d, input logic c);
        logic [7:0] f;
        f = {d[7], d == 8'h00, d[5], 1'b0, d[3], ~^d, 1'b0, c};
        return f;
    endfunction

    // driver: present one byte, push what the monitor must see next cycle
    task automatic send(input logic [7:0] b, input logic [3:0] a, input logic [2:0] s,
                        input string req, input logic [7:0] d = 8'h00, input logic c = 1'b0);
        exp_t e;
        @(negedge clk);
        op_valid  = 1'b1;
        op_byte   = b;
        port_data = d;
        carry_in  = c;
        e.act = a; e.sel = s; e.req = req;
        e.flg = (a == 4'd4 || a == 4'd6) ? in_flags(d, c) : 8'h00;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && act_valid) begin
            if (sb.size() == 0) begin
                check(0, "R9 unexpected act_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(act_code == e.act, {e.req, " act_code"}, act_code, e.act);
                check(reg_sel == e.sel, {e.req, " reg_sel"}, reg_sel, e.sel);
                check(flags_out == e.flg, {e.req, " flags_out"}, flags_out, e.flg);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(act_valid == 0 && vec_fixed == 0 && vec_from_bus == 0, "R1 outputs in reset", act_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(iff1 == 0 && iff2 == 0, "R1 iff after reset", {iff1, iff2}, 0);
        check(int_mode == 0, "R1 mode after reset", int_mode, 0);
        check(act_valid == 0, "R1 act_valid after reset", act_valid, 0);

        // R2: all NEG duplicates
        for (int k = 0; k < 8; k++) send(8'h44 + 8'(k * 8), 4'd1, 3'd0, "R2 NEG");
        idle();

        // R5: port input with several data patterns
        send(8'h40, 4'd4, 3'd0, "R5 IN B zero", 8'h00, 1'b1);
        send(8'h78, 4'd4, 3'd7, "R5 IN A neg odd", 8'h80, 1'b0);
        send(8'h58, 4'd4, 3'd3, "R5 IN E xy", 8'h28, 1'b1);
        send(8'h70, 4'd6, 3'd6, "R5 IN test", 8'hA8, 1'b0);
        send(8'h60, 4'd4, 3'd4, "R5 IN H even", 8'hFF, 1'b0);
        // R6: port output
        send(8'h41, 4'd5, 3'd0, "R6 OUT B");
        send(8'h79, 4'd5, 3'd7, "R6 OUT A");
        send(8'h71, 4'd7, 3'd6, "R6 OUT zero");
        // R7: 16-bit
        send(8'h42, 4'd8, 3'd0, "R7 SUB16 BC");
        send(8'h6A, 4'd9, 3'd2, "R7 ADD16 HL");
        send(8'h63, 4'd10, 3'd2, "R7 ST16 HL dup");
        send(8'h6B, 4'd11, 3'd2, "R7 LD16 HL dup");
        send(8'h7B, 4'd11, 3'd3, "R7 LD16 SP");
        // R8
        send(8'h77, 4'd0, 3'd0, "R8 NOP 77");
        send(8'h7F, 4'd0, 3'd0, "R8 NOP 7F");
        send(8'h47, 4'd12, 3'd0, "R8 special 47");
        send(8'h5F, 4'd12, 3'd3, "R8 special 5F");
        send(8'h67, 4'd12, 3'd4, "R8 special 67");
        // R9
        send(8'h00, 4'd0, 3'd0, "R9 NOP 00");
        send(8'hA0, 4'd0, 3'd0, "R9 NOP A0");
        send(8'hC4, 4'd0, 3'd0, "R9 NOP C4");
        send(8'h3D, 4'd0, 3'd0, "R9 NOP 3D");
        idle();
        check(act_valid == 0, "R9 idle act_valid", act_valid, 0);

        // R4: mode encodings
        send(8'h56, 4'd3, 3'd1, "R4 IM 56"); idle();
        check(int_mode == 1, "R4 mode 56", int_mode, 1);
        send(8'h7E, 4'd3, 3'd2, "R4 IM 7E"); idle();
        check(int_mode == 2, "R4 mode 7E", int_mode, 2);
        send(8'h6E, 4'd3, 3'd0, "R4 IM 6E"); idle();
        check(int_mode == 0, "R4 mode 6E", int_mode, 0);
        send(8'h76, 4'd3, 3'd1, "R4 IM 76"); idle();
        check(int_mode == 1, "R4 mode 76", int_mode, 1);

        // R12: ack while disabled
        pulse(irq_ack);
        check(vec_fixed == 0 && vec_from_bus == 0, "R12 no vector", {vec_fixed, vec_from_bus}, 0);
        check(iff1 == 0 && iff2 == 0 && int_mode == 1, "R12 state kept", {iff1, iff2, int_mode}, 1);

        // R10 / R3
        pulse(ei_req);
        check(iff1 == 1 && iff2 == 1, "R10 ei", {iff1, iff2}, 3);
        pulse(nmi_ack);
        check(iff1 == 0 && iff2 == 1, "R10 nmi", {iff1, iff2}, 1);
        send(8'h4D, 4'd2, 3'd0, "R3 RETN 4D"); idle();
        check(iff1 == 1 && iff2 == 1, "R3 iff1 restored 4D", {iff1, iff2}, 3);
        pulse(nmi_ack);
        send(8'h75, 4'd2, 3'd0, "R3 RETN 75"); idle();
        check(iff1 == 1, "R3 iff1 restored 75", iff1, 1);
        pulse(di_req);
        check(iff1 == 0 && iff2 == 0, "R10 di", {iff1, iff2}, 0);
        send(8'h45, 4'd2, 3'd0, "R3 RETN 45"); idle();
        check(iff1 == 0, "R3 iff1 copies zero", iff1, 0);

        // R11: mode 1 ack
        pulse(ei_req);
        pulse(irq_ack);
        check(vec_fixed == 1 && vec_addr == 8'h38, "R11 fixed vector", vec_addr, 8'h38);
        check(vec_from_bus == 0, "R11 no bus vector in mode 1", vec_from_bus, 0);
        check(iff1 == 0 && iff2 == 0, "R11 ack clears iff", {iff1, iff2}, 0);
        @(negedge clk);
        check(vec_fixed == 0, "R11 vector one cycle", vec_fixed, 0);

        // R11: mode 2 ack
        send(8'h5E, 4'd3, 3'd2, "R4 IM 5E"); idle();
        pulse(ei_req);
        pulse(irq_ack);
        check(vec_from_bus == 1 && vec_fixed == 0, "R11 bus vector mode 2", {vec_fixed, vec_from_bus}, 1);

        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R9 scoreboard drained", sb.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule